// File: doc/BRIEF.md
# Split-Bank Register File

This block holds 64 general registers in two 32-entry storage banks. Each bank has one read port and one write port. Together they give two reads and two writes per cycle when traffic is spread over both banks. A register identifier is 6 bits wide. Bit 5 picks the bank, and bits 4:0 pick the entry inside that bank. Register 0 is hard-wired to zero.

A read request carries two operand identifiers. When the operands sit in different banks, both values come back together one cycle after the request. When they sit in the same bank, the block reads the first operand and holds it. It reads the second operand on the next cycle and raises `stall` for that one cycle. The same applies to writes: two writes aimed at one bank commit port 0 first and port 1 one cycle later, with `stall` raised in between. While `stall` is high, every new read request and write enable is ignored, so the requester must hold it.

A restricted mode removes read serialization. In this mode, operand A always reads bank 0 and operand B always reads bank 1, each using only the 5-bit entry field. If a request names two identifiers with the same bank bit, the block does not serialize. It flags the request as illegal next to the result.

The control is two small state machines.
- The read sequencer has states RD_IDLE and RD_SECOND. It moves RD_IDLE→RD_SECOND on an accepted same-bank pair in normal mode, and RD_SECOND→RD_IDLE unconditionally after one cycle.
- The write arbiter has states WR_IDLE and WR_FLUSH. It moves WR_IDLE→WR_FLUSH on two accepted writes to one bank, and WR_FLUSH→WR_IDLE after committing the buffered write.

Top module: `split_regfile`

## Requirements
- R1: An accepted read whose operands have different bank bits (bit 5) sets `rd_valid` for the single cycle after the request edge, with both operand values on `rd_data_a`/`rd_data_b` and `stall` low.
- R2: In normal mode, an accepted read whose operands share bit 5 raises `stall` (with `rd_valid` low) for exactly the cycle after the request edge. `rd_valid` rises one cycle later with both correct values, and `rd_illegal` stays low.
- R3: Bit 5 of an identifier selects the bank and bits 4:0 the entry. A write to any of the 64 identifiers (except 0) can be read back through either read port.
- R4: With `restrict_mode` high, port A reads bank 0 at `rd_addr_a[4:0]` and port B reads bank 1 at `rd_addr_b[4:0]`. Bit 5 has no effect on the data, results arrive one cycle after the request, and `stall` stays low.
- R5: With `restrict_mode` high, `rd_illegal` is high with `rd_valid` exactly when the two request identifiers have equal bit 5. It never rises in normal mode.
- R6: Two writes to one bank in the same cycle commit port 0 at that edge and port 1 at the next edge, with `stall` high in between. For the same identifier, port 1's data is the final value. Writes to different banks both commit at once without stall.
- R7: Identifier 0 always reads as zero, and writes to it have no effect.
- R8: A read issued in the same cycle as a write to the same register returns the value from before the write.
- R9: While `stall` is high, `rd_req`, `wr0_en` and `wr1_en` are ignored: no result is produced and no register changes for them.
- R10: After reset, `rd_valid`, `rd_illegal` and `stall` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restrict_mode | input | 1 | Fixed bank per read port; same-bank pairs are flagged |
| rd_req | input | 1 | Read request |
| rd_addr_a | input | 6 | Operand A identifier |
| rd_addr_b | input | 6 | Operand B identifier |
| rd_valid | output | 1 | Operand data valid |
| rd_data_a | output | 32 | Operand A value |
| rd_data_b | output | 32 | Operand B value |
| rd_illegal | output | 1 | Same-bank pair seen in restricted mode |
| wr0_en | input | 1 | Write port 0 enable |
| wr0_addr | input | 6 | Write port 0 identifier |
| wr0_data | input | 32 | Write port 0 data |
| wr1_en | input | 1 | Write port 1 enable |
| wr1_addr | input | 6 | Write port 1 identifier |
| wr1_data | input | 32 | Write port 1 data |
| stall | output | 1 | Block busy; hold all requests |

## Verification
Reads are tried with operand pairs in opposite banks in both orders and with pairs inside bank 0 and inside bank 1. This separates the one-cycle path from the serialized path and shows that the held first operand lands on port A. Write pairs aimed at different banks, at one bank, and at one identifier separate parallel commit from buffered commit and confirm that port 1 wins. Restricted-mode reads use identifiers whose bank bit disagrees with the fixed port bank, which shows that bit 5 only drives the illegal flag. Requests presented during a stall, and a read that collides with a write, show that held inputs are dropped and that reads see pre-write contents.

// File: rtl/srf_pkg.sv
package srf_pkg;
    typedef enum logic [1:0] {
        SRC_BANK0 = 2'd0,
        SRC_BANK1 = 2'd1,
        SRC_HOLD  = 2'd2
    } opnd_src_e;

    typedef enum logic {
        RD_IDLE   = 1'b0,
        RD_SECOND = 1'b1
    } rd_state_e;

    typedef enum logic {
        WR_IDLE  = 1'b0,
        WR_FLUSH = 1'b1
    } wr_state_e;
endpackage

// File: rtl/srf_bank.sv
module srf_bank #(
    parameter int DATA_W     = 32,
    parameter int ENT_W      = 5,
    parameter bit ZERO_ENTRY = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              re,
    input  logic [ENT_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata,
    input  logic              we,
    input  logic [ENT_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata
);
    localparam int DEPTH = 1 << ENT_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we && !(ZERO_ENTRY && waddr == '0))
            mem[waddr] <= wdata;
        if (re)
            rdata <= (ZERO_ENTRY && raddr == '0) ? '0 : mem[raddr];
    end

    // R7: the hard-wired entry never yields a nonzero value
    p_zero_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ZERO_ENTRY && re && raddr == '0) |=> (rdata == '0));
endmodule

// File: rtl/srf_read_ctrl.sv
module srf_read_ctrl
    import srf_pkg::*;
#(
    parameter int IDX_W  = 6,
    parameter int DATA_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          hold,
    input  logic                          restrict_mode,
    input  logic                          req,
    input  logic [IDX_W-1:0]              addr_a,
    input  logic [IDX_W-1:0]              addr_b,
    output logic [1:0]                    bank_re,
    output logic [1:0][IDX_W-2:0]         bank_raddr,
    input  logic [1:0][DATA_W-1:0]        bank_rdata,
    output logic                          valid,
    output logic                          illegal,
    output logic [DATA_W-1:0]             data_a,
    output logic [DATA_W-1:0]             data_b,
    output logic                          busy
);
    localparam int ENT_W = IDX_W - 1;

    rd_state_e         state_q, state_d;
    logic              pend_bank_q;
    logic [ENT_W-1:0]  pend_idx_q;
    logic              valid_q, illegal_q;
    opnd_src_e         a_src_q;
    logic              b_bank_q;
    logic [DATA_W-1:0] held_q;

    logic             accept, bank_a, bank_b, same_bank;
    logic [ENT_W-1:0] idx_a, idx_b;

    assign accept    = req && !hold;
    assign bank_a    = addr_a[IDX_W-1];
    assign bank_b    = addr_b[IDX_W-1];
    assign idx_a     = addr_a[ENT_W-1:0];
    assign idx_b     = addr_b[ENT_W-1:0];
    assign same_bank = (bank_a == bank_b);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE:   if (accept && !restrict_mode && same_bank) state_d = RD_SECOND;
            RD_SECOND: state_d = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RD_IDLE;
        else        state_q <= state_d;
    end

    // bank read port steering
    always_comb begin
        bank_re    = '0;
        bank_raddr = '0;
        unique case (state_q)
            RD_IDLE: begin
                if (accept) begin
                    if (restrict_mode) begin
                        bank_re[0]    = 1'b1;
                        bank_raddr[0] = idx_a;
                        bank_re[1]    = 1'b1;
                        bank_raddr[1] = idx_b;
                    end else begin
                        bank_re[bank_a]    = 1'b1;
                        bank_raddr[bank_a] = idx_a;
                        if (!same_bank) begin
                            bank_re[bank_b]    = 1'b1;
                            bank_raddr[bank_b] = idx_b;
                        end
                    end
                end
            end
            RD_SECOND: begin
                bank_re[pend_bank_q]    = 1'b1;
                bank_raddr[pend_bank_q] = pend_idx_q;
            end
        endcase
    end

    // registered result control
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q   <= 1'b0;
            illegal_q <= 1'b0;
        end else begin
            valid_q   <= 1'b0;
            illegal_q <= 1'b0;
            unique case (state_q)
                RD_IDLE: begin
                    if (accept) begin
                        if (restrict_mode) begin
                            valid_q   <= 1'b1;
                            illegal_q <= same_bank;
                            a_src_q   <= SRC_BANK0;
                            b_bank_q  <= 1'b1;
                        end else if (same_bank) begin
                            pend_bank_q <= bank_a;
                            pend_idx_q  <= idx_b;
                        end else begin
                            valid_q  <= 1'b1;
                            a_src_q  <= bank_a ? SRC_BANK1 : SRC_BANK0;
                            b_bank_q <= bank_b;
                        end
                    end
                end
                RD_SECOND: begin
                    held_q   <= bank_rdata[pend_bank_q];
                    a_src_q  <= SRC_HOLD;
                    b_bank_q <= pend_bank_q;
                    valid_q  <= 1'b1;
                end
            endcase
        end
    end

    always_comb begin
        case (a_src_q)
            SRC_BANK0: data_a = bank_rdata[0];
            SRC_BANK1: data_a = bank_rdata[1];
            default:   data_a = held_q;
        endcase
    end

    assign data_b  = bank_rdata[b_bank_q];
    assign valid   = valid_q;
    assign illegal = illegal_q;
    assign busy    = (state_q == RD_SECOND);

    // R2: serialization costs exactly one cycle
    p_second_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RD_SECOND) |=> (state_q == RD_IDLE));
    // R2: the cycle after the second read delivers the pair
    p_second_delivers_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RD_SECOND) |=> valid_q);
    // R2: no result during the stall cycle
    p_quiet_in_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RD_SECOND) |-> !valid_q);
    // R4: restricted mode never serializes
    p_restrict_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && restrict_mode) |=> (state_q == RD_IDLE && valid_q));
    // R5: the illegal flag only accompanies a result
    p_illegal_with_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_q |-> valid_q);
    // R9: a held request yields nothing
    p_held_no_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && state_q == RD_IDLE) |=> !valid_q);
endmodule

// File: rtl/srf_write_arb.sv
module srf_write_arb
    import srf_pkg::*;
#(
    parameter int IDX_W  = 6,
    parameter int DATA_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   hold,
    input  logic                   we0,
    input  logic [IDX_W-1:0]       wa0,
    input  logic [DATA_W-1:0]      wd0,
    input  logic                   we1,
    input  logic [IDX_W-1:0]       wa1,
    input  logic [DATA_W-1:0]      wd1,
    output logic [1:0]             bank_we,
    output logic [1:0][IDX_W-2:0]  bank_waddr,
    output logic [1:0][DATA_W-1:0] bank_wdata,
    output logic                   busy
);
    localparam int ENT_W = IDX_W - 1;

    wr_state_e         state_q, state_d;
    logic              buf_bank_q;
    logic [ENT_W-1:0]  buf_idx_q;
    logic [DATA_W-1:0] buf_data_q;

    logic acc0, acc1, clash, bank0_sel, bank1_sel;

    assign acc0      = we0 && !hold;
    assign acc1      = we1 && !hold;
    assign bank0_sel = wa0[IDX_W-1];
    assign bank1_sel = wa1[IDX_W-1];
    assign clash     = acc0 && acc1 && (bank0_sel == bank1_sel);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WR_IDLE:  if (clash) state_d = WR_FLUSH;
            WR_FLUSH: state_d = WR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WR_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (state_q == WR_IDLE && clash) begin
            buf_bank_q <= bank1_sel;
            buf_idx_q  <= wa1[ENT_W-1:0];
            buf_data_q <= wd1;
        end
    end

    always_comb begin
        bank_we    = '0;
        bank_waddr = '0;
        bank_wdata = '0;
        unique case (state_q)
            WR_IDLE: begin
                if (acc0) begin
                    bank_we[bank0_sel]    = 1'b1;
                    bank_waddr[bank0_sel] = wa0[ENT_W-1:0];
                    bank_wdata[bank0_sel] = wd0;
                end
                if (acc1 && !clash) begin
                    bank_we[bank1_sel]    = 1'b1;
                    bank_waddr[bank1_sel] = wa1[ENT_W-1:0];
                    bank_wdata[bank1_sel] = wd1;
                end
            end
            WR_FLUSH: begin
                bank_we[buf_bank_q]    = 1'b1;
                bank_waddr[buf_bank_q] = buf_idx_q;
                bank_wdata[buf_bank_q] = buf_data_q;
            end
        endcase
    end

    assign busy = (state_q == WR_FLUSH);

    // R6: buffered write drains in one cycle
    p_flush_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WR_FLUSH) |=> (state_q == WR_IDLE));
    // R9: held write enables reach no bank
    p_held_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && state_q == WR_IDLE) |-> (bank_we == '0));
endmodule

// File: rtl/split_regfile.sv
module split_regfile #(
    parameter int IDX_W  = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restrict_mode,
    input  logic              rd_req,
    input  logic [IDX_W-1:0]  rd_addr_a,
    input  logic [IDX_W-1:0]  rd_addr_b,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data_a,
    output logic [DATA_W-1:0] rd_data_b,
    output logic              rd_illegal,
    input  logic              wr0_en,
    input  logic [IDX_W-1:0]  wr0_addr,
    input  logic [DATA_W-1:0] wr0_data,
    input  logic              wr1_en,
    input  logic [IDX_W-1:0]  wr1_addr,
    input  logic [DATA_W-1:0] wr1_data,
    output logic              stall
);
    localparam int ENT_W = IDX_W - 1;

    logic                   rd_busy, wr_busy;
    logic [1:0]             b_re, b_we;
    logic [1:0][ENT_W-1:0]  b_raddr, b_waddr;
    logic [1:0][DATA_W-1:0] b_rdata, b_wdata;

    assign stall = rd_busy || wr_busy;

    srf_read_ctrl #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .hold(stall), .restrict_mode(restrict_mode),
        .req(rd_req), .addr_a(rd_addr_a), .addr_b(rd_addr_b),
        .bank_re(b_re), .bank_raddr(b_raddr), .bank_rdata(b_rdata),
        .valid(rd_valid), .illegal(rd_illegal),
        .data_a(rd_data_a), .data_b(rd_data_b), .busy(rd_busy)
    );

    srf_write_arb #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_wr (
        .clk(clk), .rst_n(rst_n), .hold(stall),
        .we0(wr0_en), .wa0(wr0_addr), .wd0(wr0_data),
        .we1(wr1_en), .wa1(wr1_addr), .wd1(wr1_data),
        .bank_we(b_we), .bank_waddr(b_waddr), .bank_wdata(b_wdata),
        .busy(wr_busy)
    );

    for (genvar g = 0; g < 2; g++) begin : g_bank
        srf_bank #(.DATA_W(DATA_W), .ENT_W(ENT_W), .ZERO_ENTRY(g == 0)) u_bank (
            .clk(clk), .rst_n(rst_n),
            .re(b_re[g]), .raddr(b_raddr[g]), .rdata(b_rdata[g]),
            .we(b_we[g]), .waddr(b_waddr[g]), .wdata(b_wdata[g])
        );
    end

    // R5: normal mode never reports an illegal pair
    p_no_illegal_normal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !restrict_mode |=> !rd_illegal);
    // R6: a same-bank write pair raises stall on the next cycle
    p_write_clash_stalls_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && wr0_en && wr1_en && wr0_addr[IDX_W-1] == wr1_addr[IDX_W-1]) |=> stall);
endmodule

// File: tb/sim_split_regfile.sv
module sim_split_regfile;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n, restrict_mode, rd_req;
    logic [5:0]  rd_addr_a, rd_addr_b;
    logic        rd_valid, rd_illegal, stall;
    logic [31:0] rd_data_a, rd_data_b;
    logic        wr0_en, wr1_en;
    logic [5:0]  wr0_addr, wr1_addr;
    logic [31:0] wr0_data, wr1_data;

    int n_checks = 0;
    int n_bad    = 0;
    logic [31:0] exp_mem [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    split_regfile u0 (
        .clk(clk), .rst_n(rst_n), .restrict_mode(restrict_mode),
        .rd_req(rd_req), .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
        .rd_valid(rd_valid), .rd_data_a(rd_data_a), .rd_data_b(rd_data_b),
        .rd_illegal(rd_illegal),
        .wr0_en(wr0_en), .wr0_addr(wr0_addr), .wr0_data(wr0_data),
        .wr1_en(wr1_en), .wr1_addr(wr1_addr), .wr1_data(wr1_data),
        .stall(stall)
    );

    function automatic logic [31:0] pat(int id);
        return 32'h1000_0000 + id * 32'h0001_0203;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic idle_inputs();
        rd_req = 1'b0; wr0_en = 1'b0; wr1_en = 1'b0;
    endtask

    // drive one read; check timing, data and flag
    task automatic do_read(logic [5:0] a, logic [5:0] b, bit exp_stall,
                           logic [31:0] ea, logic [31:0] eb, bit exp_ill, string tag);
        @(negedge clk);
        rd_req = 1'b1; rd_addr_a = a; rd_addr_b = b;
        @(negedge clk);
        rd_req = 1'b0;
        chk({tag, " stall"}, 32'(stall), 32'(exp_stall));
        if (exp_stall) begin
            chk({tag, " no valid in stall"}, 32'(rd_valid), 32'd0);
            @(negedge clk);
            chk({tag, " stall cleared"}, 32'(stall), 32'd0);
        end
        chk({tag, " valid"}, 32'(rd_valid), 32'd1);
        chk({tag, " data a"}, rd_data_a, ea);
        chk({tag, " data b"}, rd_data_b, eb);
        chk({tag, " illegal"}, 32'(rd_illegal), 32'(exp_ill));
    endtask

    task automatic t_reset();
        chk("R10 valid", 32'(rd_valid), 32'd0);
        chk("R10 stall", 32'(stall), 32'd0);
        chk("R10 illegal", 32'(rd_illegal), 32'd0);
    endtask

    task automatic t_fill();
        for (int k = 0; k < 32; k++) begin
            @(negedge clk);
            wr0_en = 1'b1; wr0_addr = 6'(k);      wr0_data = pat(k);
            wr1_en = 1'b1; wr1_addr = 6'(k + 32); wr1_data = pat(k + 32);
            exp_mem[k]      = (k == 0) ? 32'd0 : pat(k);
            exp_mem[k + 32] = pat(k + 32);
            if (k > 0) chk("R6 cross-bank writes no stall", 32'(stall), 32'd0);
        end
        @(negedge clk);
        idle_inputs();
        chk("R6 cross-bank writes no stall", 32'(stall), 32'd0);
    endtask

    task automatic t_diff_bank();
        do_read(6'd5,  6'd40, 1'b0, exp_mem[5],  exp_mem[40], 1'b0, "R1 (5,40)");
        do_read(6'd33, 6'd2,  1'b0, exp_mem[33], exp_mem[2],  1'b0, "R1 (33,2)");
        do_read(6'd63, 6'd31, 1'b0, exp_mem[63], exp_mem[31], 1'b0, "R3 (63,31)");
        do_read(6'd32, 6'd1,  1'b0, exp_mem[32], exp_mem[1],  1'b0, "R3 (32,1)");
    endtask

    task automatic t_same_bank();
        do_read(6'd7,  6'd12, 1'b1, exp_mem[7],  exp_mem[12], 1'b0, "R2 bank0 (7,12)");
        do_read(6'd35, 6'd60, 1'b1, exp_mem[35], exp_mem[60], 1'b0, "R2 bank1 (35,60)");
        do_read(6'd60, 6'd35, 1'b1, exp_mem[60], exp_mem[35], 1'b0, "R2 bank1 (60,35)");
    endtask

    task automatic t_write_clash();
        @(negedge clk);
        wr0_en = 1'b1; wr0_addr = 6'd3; wr0_data = 32'hAAAA_0003;
        wr1_en = 1'b1; wr1_addr = 6'd9; wr1_data = 32'hBBBB_0009;
        @(negedge clk);
        idle_inputs();
        chk("R6 clash stall", 32'(stall), 32'd1);
        @(negedge clk);
        chk("R6 clash stall ends", 32'(stall), 32'd0);
        exp_mem[3] = 32'hAAAA_0003;
        exp_mem[9] = 32'hBBBB_0009;
        do_read(6'd3, 6'd9, 1'b1, exp_mem[3], exp_mem[9], 1'b0, "R6 clash readback");
        @(negedge clk);
        wr0_en = 1'b1; wr0_addr = 6'd10; wr0_data = 32'hCCCC_0010;
        wr1_en = 1'b1; wr1_addr = 6'd10; wr1_data = 32'hDDDD_0010;
        @(negedge clk);
        idle_inputs();
        chk("R6 same id stall", 32'(stall), 32'd1);
        exp_mem[10] = 32'hDDDD_0010;
        do_read(6'd10, 6'd44, 1'b0, exp_mem[10], exp_mem[44], 1'b0, "R6 port1 wins");
    endtask

    task automatic t_zero();
        @(negedge clk);
        wr0_en = 1'b1; wr0_addr = 6'd0; wr0_data = 32'hFFFF_FFFF;
        @(negedge clk);
        idle_inputs();
        do_read(6'd0, 6'd33, 1'b0, 32'd0, exp_mem[33], 1'b0, "R7 zero port a");
        do_read(6'd34, 6'd0, 1'b0, exp_mem[34], 32'd0, 1'b0, "R7 zero port b");
    endtask

    task automatic t_old_value();
        logic [31:0] old20;
        old20 = exp_mem[20];
        @(negedge clk);
        wr0_en = 1'b1; wr0_addr = 6'd20; wr0_data = 32'h5555_0020;
        rd_req = 1'b1; rd_addr_a = 6'd20; rd_addr_b = 6'd50;
        @(negedge clk);
        idle_inputs();
        chk("R8 valid", 32'(rd_valid), 32'd1);
        chk("R8 old value", rd_data_a, old20);
        exp_mem[20] = 32'h5555_0020;
        do_read(6'd20, 6'd50, 1'b0, exp_mem[20], exp_mem[50], 1'b0, "R8 new value");
    endtask

    task automatic t_held();
        @(negedge clk);
        rd_req = 1'b1; rd_addr_a = 6'd7; rd_addr_b = 6'd12;
        @(negedge clk);
        chk("R9 stall seen", 32'(stall), 32'd1);
        rd_addr_a = 6'd1; rd_addr_b = 6'd33;
        wr0_en = 1'b1; wr0_addr = 6'd15; wr0_data = 32'h9999_0015;
        @(negedge clk);
        idle_inputs();
        chk("R9 first request data b", rd_data_b, exp_mem[12]);
        @(negedge clk);
        chk("R9 held request dropped", 32'(rd_valid), 32'd0);
        do_read(6'd15, 6'd47, 1'b0, exp_mem[15], exp_mem[47], 1'b0, "R9 held write dropped");
    endtask

    task automatic t_restrict();
        @(negedge clk);
        restrict_mode = 1'b1;
        do_read(6'h25, 6'h03, 1'b0, exp_mem[5], exp_mem[35], 1'b0, "R4 fixed banks");
        do_read(6'h05, 6'h03, 1'b0, exp_mem[5], exp_mem[35], 1'b1, "R5 bank0 pair flagged");
        do_read(6'h20, 6'h23, 1'b0, 32'd0, exp_mem[35], 1'b1, "R5 bank1 pair flagged");
        @(negedge clk);
        restrict_mode = 1'b0;
        do_read(6'h05, 6'h03, 1'b1, exp_mem[5], exp_mem[3], 1'b0, "R5 normal no flag");
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; restrict_mode = 1'b0;
        rd_addr_a = '0; rd_addr_b = '0;
        wr0_addr = '0; wr1_addr = '0; wr0_data = '0; wr1_data = '0;
        idle_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill();
        t_diff_bank();
        t_same_bank();
        t_write_clash();
        t_zero();
        t_old_value();
        t_held();
        t_restrict();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end
endmodule